// File: doc/BRIEF.md
# Period-Match Timer with Postscaler

This block is an 8-bit up-counter that advances on prescaled qualifying ticks and returns to zero as soon as it has passed the value held in a programmable period register. A free-running overflow does not set its rate; the period register does. Every such compare-clear produces a one-cycle match pulse, which a serial unit can take as its baud-rate tick. The same pulse also feeds a 4-bit postscaler, which sets a sticky interrupt flag once every 1 to 16 matches.

Software reaches three registers through a simple single-cycle bus. These are the live count, the period value and a control word. The control word holds the run enable, a 2-bit prescale code and a 4-bit postscale code. Writing the count or the control word restarts both scalers from zero, and a reset clears them too. The interrupt output is the flag qualified by an enable input. A dedicated pulse input clears the flag.

Top module: `period_timer`

## Requirements
- R1: After reset the count reads 0x00, the period reads 0xFF, the control word reads 0x00, and irq_flag, irq and match_tick are low.
- R2: Control bits [2:1] pick the prescale. Code 00 advances the count on every qualified tick, code 01 on every 4th, and codes 10 and 11 on every 16th. A tick is qualified only when tick_in is high and the timer is running. Cycles with tick_in low change nothing.
- R3: On each prescaled step the count goes up by one. When the count already equals the period, the step instead clears it to 0x00. In the cycle after that clearing edge, match_tick is high for exactly one cycle, and the count reads 0x00 in that cycle.
- R4: Control bits [6:3] hold a code K. Every (K+1)th match sets irq_flag, and the flag rises in the same cycle as the match_tick of that match.
- R5: irq_flag stays set until flag_clr is high at a clock edge. If a new flag-setting match arrives at that same edge, the set wins. irq equals irq_flag AND irq_en.
- R6: A bus write to address 0 loads the count with the written data. It also clears the prescaler and the postscaler, and no step happens in that cycle.
- R7: A bus write to address 2 replaces the control word and clears the prescaler and the postscaler.
- R8: While control bit 0 (run) is 0, the count holds its value, no match_tick is produced and the prescaler does not advance.
- R9: bus_rdata is combinational. Address 0 returns the count, address 1 the period, address 2 the control word with bit 7 as zero, and address 3 returns zero. A write to address 1 sets the period, and the compare uses the new value from the following cycle on.
- R10: If the period is set below the current count, the count keeps rising through 0xFF and wraps to 0x00 with no match on the way. It matches when it next reaches the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | Internal tick qualifier; one count event per high cycle |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register select: 0 count, 1 period, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the interrupt flag |
| match_tick | output | 1 | One-cycle pulse after each compare-clear (baud tick) |
| irq_flag | output | 1 | Sticky postscaled match flag |
| irq | output | 1 | irq_flag gated by irq_en |

## Verification
Directed runs of continuous ticks under each prescale code check that the step counts come out as 1, 4 and 16 per step, which separates the 01 code from the two 1x codes. Short periods combined with postscale codes 0, 1 and 2 show where the flag lands. Count writes and control writes made part-way through a postscale cycle show whether the scalers really restart. A period written below the count shows that the wrap passes through 0xFF without a false match. Long constrained-random runs then mix gapped ticks, random writes to every address, flag clears and enable changes, and compare every cycle against a bench model of the requirements. These runs catch interactions such as a write landing on a step edge, or a clear coinciding with a flag set.

// File: rtl/tmr_pkg.sv
// Package: shared register addresses, control word layout and the
// prescale decode for the period-match timer.
// Assumes an 8-bit data bus and a 2-bit register address.
package tmr_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int PSC_W   = 2;
    localparam int POST_W  = 4;
    localparam int PRE_W   = 4;
    localparam int CTRL_W  = 1 + PSC_W + POST_W;

    typedef enum logic [ADDR_W-1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Control word: post code [6:3], prescale code [2:1], run [0]
    typedef struct packed {
        logic [POST_W-1:0] post;
        logic [PSC_W-1:0]  psc;
        logic              run;
    } ctrl_t;

    // Last prescaler state before a step: divide 1, 4 or 16
    function automatic logic [PRE_W-1:0] psc_last(input logic [PSC_W-1:0] code);
        logic [PRE_W-1:0] r;
        unique case (code)
            2'b00:   r = PRE_W'(0);
            2'b01:   r = PRE_W'(3);
            default: r = PRE_W'(15);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
// Prescaler: divides qualified ticks by 1, 4 or 16 and emits a step
// on the last tick of each group. Assumes clr and tick come from the
// same clock domain; clr wins over tick and suppresses the step.
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [PSC_W-1:0] code,
    output logic             step
);

    logic [PW-1:0] acc_q;
    logic [PW-1:0] last;
    logic          at_last;

    assign last    = PW'(psc_last(code));
    assign at_last = (acc_q >= last);
    assign step    = tick & at_last & ~clr;

    // Tick accumulator: restarts on clear or after the last tick of a group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= at_last ? '0 : acc_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_postscale.sv
// Postscaler: counts match events and fires on every (code+1)th one.
// Assumes code is stable between clears; >= keeps it safe if not.
module tmr_postscale
    import tmr_pkg::*;
#(
    parameter int QW = POST_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          evt,
    input  logic [QW-1:0] code,
    output logic          fire
);

    logic [QW-1:0] cnt_q;
    logic          full;

    assign full = (cnt_q >= code);
    assign fire = evt & full & ~clr;

    // Event counter: restarts on clear or after firing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (evt) begin
            cnt_q <= full ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_period_counter.sv
// Period counter: steps up by one, clears when a step finds the count
// equal to the period, and loads from the bus with top priority.
// Assumes step is already forced low in a load cycle by the caller.
module tmr_period_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         hit
);

    logic [W-1:0] count_q;

    assign count = count_q;
    assign hit   = step & (count_q == period);

    // Count register: load, compare-clear, or increment (wraps at max)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (hit) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/period_timer.sv
// Top: register bus, control decode, scalers, counter, match pulse
// and interrupt flag of the period-match timer.
// Assumes single-cycle bus writes and a synchronous tick qualifier.
module period_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              match_tick,
    output logic              irq_flag,
    output logic              irq
);

    localparam logic [DATA_W-1:0] PERIOD_RST = {DATA_W{1'b1}};

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] period_q;
    logic [DATA_W-1:0] count_q;
    logic              wr_count;
    logic              wr_period;
    logic              wr_ctrl;
    logic              scl_clr;
    logic              step;
    logic              hit;
    logic              fire;
    logic              match_q;
    logic              flag_q;

    assign wr_count  = bus_wr & (bus_addr == SEL_COUNT);
    assign wr_period = bus_wr & (bus_addr == SEL_PERIOD);
    assign wr_ctrl   = bus_wr & (bus_addr == SEL_CTRL);
    assign scl_clr   = wr_count | wr_ctrl;

    // Control and period registers written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            period_q <= PERIOD_RST;
        end else begin
            if (wr_ctrl)   ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_period) period_q <= bus_wdata;
        end
    end

    tmr_prescale #(.PW(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (scl_clr),
        .tick  (tick_in & ctrl_q.run),
        .code  (ctrl_q.psc),
        .step  (step)
    );

    tmr_period_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_count),
        .load_val (bus_wdata),
        .step     (step),
        .period   (period_q),
        .count    (count_q),
        .hit      (hit)
    );

    tmr_postscale #(.QW(POST_W)) u_post (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (scl_clr),
        .evt   (hit),
        .code  (ctrl_q.post),
        .fire  (fire)
    );

    // Match pulse register and sticky flag (set wins over clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            match_q <= hit;
            if (fire)          flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign match_tick = match_q;
    assign irq_flag   = flag_q;
    assign irq        = flag_q & irq_en;

    // Read mux for the three registers
    always_comb begin
        unique case (bus_addr)
            SEL_COUNT:  bus_rdata = count_q;
            SEL_PERIOD: bus_rdata = period_q;
            SEL_CTRL:   bus_rdata = DATA_W'(ctrl_q);
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/period_timer_checker.sv
// Checker: temporal properties of the period-match timer, bound to
// the top. Assumes the top's internal count and run bit are visible.
module period_timer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       flag_clr,
    input logic       match_tick,
    input logic       irq_flag,
    input logic [7:0] count,
    input logic       timer_on
);

    AST_MATCH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        match_tick |-> (count == 8'd0)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(count) && !$past(bus_wr && bus_addr == 2'd0))
        |-> ((count == 8'($past(count) + 8'd1)) || (count == 8'd0))); // R3

    AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> (count == $past(bus_wdata))); // R6

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_on && !(bus_wr && bus_addr == 2'd0)) |=> $stable(count)); // R8

    AST_STOP_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_on |=> !match_tick); // R8

    AST_FLAG_WITH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> match_tick); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag); // R5

endmodule

bind period_timer period_timer_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .flag_clr   (flag_clr),
    .match_tick (match_tick),
    .irq_flag   (irq_flag),
    .count      (count_q),
    .timer_on   (ctrl_q.run)
);

// File: tb/period_timer_bench.sv
// Bench: directed corner cases and seeded random traffic, checked
// every cycle against a behavioural model built from the requirements.
module period_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       match_tick;
    logic       irq_flag;
    logic       irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    period_timer u_period_timer (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_en(irq_en), .flag_clr(flag_clr), .match_tick(match_tick),
        .irq_flag(irq_flag), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_cnt, m_per;
    logic [6:0] m_ctrl;
    int         m_ticks;   // qualified ticks seen in current prescale group
    int         m_matches; // matches seen in current postscale group
    logic       m_flag, m_match;

    function automatic int div_of(input logic [1:0] code);
        return (code == 2'b00) ? 1 : (code == 2'b01) ? 4 : 16;
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_per;
            2'd2: return {1'b0, m_ctrl};
            default: return 8'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 8'd0; m_per = 8'hFF; m_ctrl = 7'd0;
            m_ticks = 0; m_matches = 0; m_flag = 1'b0; m_match = 1'b0;
        end else begin
            bit wc, wp, wk, restart, qual, stp, mt, fr;
            wc = bus_wr && bus_addr == 2'd0;
            wp = bus_wr && bus_addr == 2'd1;
            wk = bus_wr && bus_addr == 2'd2;
            restart = wc || wk;
            qual = tick_in && m_ctrl[0];
            stp = 1'b0;
            if (restart) m_ticks = 0;
            else if (qual) begin
                m_ticks = m_ticks + 1;
                if (m_ticks == div_of(m_ctrl[2:1])) begin
                    stp = 1'b1;
                    m_ticks = 0;
                end
            end
            mt = stp && (m_cnt == m_per);
            fr = 1'b0;
            if (restart) m_matches = 0;
            else if (mt) begin
                m_matches = m_matches + 1;
                if (m_matches == int'(m_ctrl[6:3]) + 1) begin
                    fr = 1'b1;
                    m_matches = 0;
                end
            end
            if (wc) m_cnt = bus_wdata;
            else if (mt) m_cnt = 8'd0;
            else if (stp) m_cnt = m_cnt + 8'd1;
            if (fr) m_flag = 1'b1;
            else if (flag_clr) m_flag = 1'b0;
            m_match = mt;
            if (wk) m_ctrl = bus_wdata[6:0];
            if (wp) m_per = bus_wdata;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, sampled well after the falling edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            check("R3", "match_tick", match_tick, m_match);
            check("R4", "irq_flag", irq_flag, m_flag);
            check("R5", "irq", irq, m_flag & irq_en);
            check("R9", "bus_rdata", bus_rdata, exp_read(bus_addr));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic run(input int n, input logic t);
        tick_in = t;
        repeat (n) @(negedge clk);
        tick_in = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #3;
        check(req, "read", bus_rdata, exp);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input logic [3:0] k, input logic [1:0] p, input logic on);
        return {1'b0, k, p, on};
    endfunction

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd("R1", 2'd0, 8'h00);
        rd("R1", 2'd1, 8'hFF);
        rd("R1", 2'd2, 8'h00);
        check("R1", "irq_flag", irq_flag, 1'b0);
        check("R1", "match_tick", match_tick, 1'b0);
        // R8 stopped: ticks do nothing
        run(10, 1'b1);
        rd("R8", 2'd0, 8'h00);
        // R2 prescale 1:4
        wr(2'd2, ctl(4'd0, 2'b01, 1'b1));
        wr(2'd0, 8'd0);
        run(40, 1'b1);
        rd("R2", 2'd0, 8'd10);
        run(10, 1'b0);                      // R2 idle tick_in cycles
        rd("R2", 2'd0, 8'd10);
        // R2 prescale codes 10 and 11
        wr(2'd2, ctl(4'd0, 2'b10, 1'b1));
        wr(2'd0, 8'd0);
        run(32, 1'b1);
        rd("R2", 2'd0, 8'd2);
        wr(2'd2, ctl(4'd0, 2'b11, 1'b1));
        wr(2'd0, 8'd0);
        run(33, 1'b1);
        rd("R2", 2'd0, 8'd2);
        wr(2'd2, ctl(4'd0, 2'b00, 1'b1));
        wr(2'd0, 8'd0);
        run(7, 1'b1);
        rd("R2", 2'd0, 8'd7);
        // R9 period write readback
        wr(2'd1, 8'h5A);
        rd("R9", 2'd1, 8'h5A);
        rd("R9", 2'd3, 8'h00);
        // R3 period 3: clears on 4th step, pulse one cycle
        wr(2'd1, 8'd3);
        wr(2'd0, 8'd0);
        run(3, 1'b1);
        rd("R3", 2'd0, 8'd3);
        check("R3", "no match yet", match_tick, 1'b0);
        run(1, 1'b1);
        rd("R3", 2'd0, 8'd0);
        check("R3", "match pulse", match_tick, 1'b1);
        run(1, 1'b0);
        check("R3", "pulse width", match_tick, 1'b0);
        // R4 postscale 1:3 with period 2
        wr(2'd2, ctl(4'd2, 2'b00, 1'b1));
        wr(2'd1, 8'd2);
        wr(2'd0, 8'd0);
        clear_flag();
        run(8, 1'b1);
        check("R4", "flag after 8", irq_flag, 1'b0);
        run(1, 1'b1);
        check("R4", "flag after 9", irq_flag, 1'b1);
        // R5 gating and clear
        irq_en = 1'b1;
        #3 check("R5", "irq enabled", irq, 1'b1);
        irq_en = 1'b0;
        #1 check("R5", "irq masked", irq, 1'b0);
        clear_flag();
        #3 check("R5", "flag cleared", irq_flag, 1'b0);
        // R6 count write restarts postscaler (1:2, period 1)
        wr(2'd2, ctl(4'd1, 2'b00, 1'b1));
        wr(2'd1, 8'd1);
        wr(2'd0, 8'd0);
        run(2, 1'b1);
        wr(2'd0, 8'd0);
        run(2, 1'b1);
        check("R6", "flag after restart", irq_flag, 1'b0);
        run(2, 1'b1);
        check("R6", "flag second match", irq_flag, 1'b1);
        wr(2'd0, 8'h80);
        rd("R6", 2'd0, 8'h80);
        // R7 control write restarts postscaler
        clear_flag();
        wr(2'd0, 8'd0);
        run(2, 1'b1);
        wr(2'd2, ctl(4'd1, 2'b00, 1'b1));
        run(2, 1'b1);
        check("R7", "flag after restart", irq_flag, 1'b0);
        run(2, 1'b1);
        check("R7", "flag second match", irq_flag, 1'b1);
        // R10 period below count wraps
        wr(2'd2, ctl(4'd0, 2'b00, 1'b1));
        wr(2'd0, 8'd10);
        wr(2'd1, 8'd5);
        clear_flag();
        run(246, 1'b1);
        rd("R10", 2'd0, 8'd0);
        check("R10", "no match in wrap", irq_flag, 1'b0);
        run(6, 1'b1);
        check("R10", "match at period", irq_flag, 1'b1);
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            tick_in   = ($urandom_range(0, 9) < 7);
            flag_clr  = ($urandom_range(0, 19) == 0);
            irq_en    = $urandom_range(0, 1);
            bus_wr    = ($urandom_range(0, 11) == 0);
            bus_addr  = 2'($urandom_range(0, 3));
            bus_wdata = 8'($urandom_range(0, 255));
            if (bus_wr && bus_addr == 2'd1) bus_wdata = 8'($urandom_range(0, 12));
            if (bus_wr && bus_addr == 2'd2)
                bus_wdata = ctl(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
                                ($urandom_range(0, 4) != 0));
        end
        @(negedge clk);
        bus_wr = 1'b0; tick_in = 1'b0; flag_clr = 1'b0;
        repeat (2) @(negedge clk);
        #4;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule